// File: doc/BRIEF.md
# Interrupt Flag Aggregation Unit

This block gathers interrupt events for an 8051-class processor core and produces one request line per interrupt vector. Two external pins are synchronized on the way in. Each pin is qualified as either a falling-edge or a low-level source, chosen by its own mode bit. Peripheral events reach the block as single-cycle set pulses. These come from three timers, two UARTs, an SPI port, an I2C port and an ADC. Each pulse sets a sticky flag.

Where a vector serves several flags, the request is the OR of those flags. The individual flags stay visible on a readback bus, so the service routine can find the cause. Software clears any flag with a per-flag clear strobe. When the core acknowledges a vector, the block clears only the flags that hardware may retire on its own. These are the edge-mode external flags and the Timer 0 and Timer 1 overflow flags. Masking and priority belong to the core.

Top module: `irq_agg`

## Requirements
- R1: After reset, every bit of `flag_o` and `irq_o` is 0.
- R2: With `ext_edge_i[n]`=1, a falling edge on `ext_pin_i[n]` sets its flag on the third rising clock edge after the pin changes. A pin that is held low afterwards does not set the flag again.
- R3: An acknowledge of vector 0 clears the ext0 flag, and an acknowledge of vector 2 clears the ext1 flag. The clear happens only while that channel is in edge mode. An acknowledge of any other vector leaves the flag unchanged.
- R4: With `ext_edge_i[n]`=0, the flag sets while the synchronized pin is low. An acknowledge never clears it. A software clear has no effect while the pin is low, and takes effect once the synchronized pin is high.
- R5: Pulses on `tmr_ovf_i[0]` and `tmr_ovf_i[1]` set flags 2 and 3. These flags drive vectors 1 and 3, and an acknowledge of vectors 1 and 3 clears them. While `t0_mode3_i`=1, vector 1 stays low, but flag 2 still sets.
- R6: Vector 5 is the OR of the Timer 2 overflow flag (bit 4) and the Timer 2 external flag (bit 5). Bit 5 sets on a falling edge of `t2x_pin_i`, with the same latency as R2. An acknowledge of vector 5 clears neither flag.
- R7: Vector 4 is the OR of the UART0 flags (receive bit 6, transmit bit 7). Vector 9 is the OR of the UART1 flags (receive bit 8, transmit bit 9). An acknowledge does not clear these flags.
- R8: Vector 6 is the OR of the four SPI flags in bits 10 to 13. Bit 10 is transmit end, bit 11 receive overrun, bit 12 transmit buffer empty and bit 13 receive buffer full. Each flag is set by the matching bit of `spi_evt_i`.
- R9: Any bit of `i2c_evt_i` sets flag 14, which drives vector 7. The four bits are address match, general call, STOP and byte done. `adc_done_i` sets flag 15, which drives vector 8.
- R10: If a hardware set and a software clear or acknowledge clear of the same flag fall in the same cycle, the flag ends up set.
- R11: A pulse on `sw_clr_i[k]` clears flag k on the next edge, unless a set coincides. An acknowledge of vectors 10 to 15 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 2 | External interrupt pins (asynchronous) |
| ext_edge_i | input | 2 | Per-pin mode: 1 selects falling edge, 0 selects low level |
| t2x_pin_i | input | 1 | Timer 2 external pin (asynchronous) |
| t0_mode3_i | input | 1 | Timer 0 is running in mode 3 |
| tmr_ovf_i | input | 3 | Overflow set pulses for Timers 0, 1 and 2 |
| uart_rx_done_i | input | 2 | Receive-complete pulses for UART0 and UART1 |
| uart_tx_done_i | input | 2 | Transmit-complete pulses for UART0 and UART1 |
| spi_evt_i | input | 4 | SPI set pulses: tx end, rx overrun, tx empty, rx full |
| i2c_evt_i | input | 4 | I2C event pulses: address, general call, STOP, byte done |
| adc_done_i | input | 1 | Conversion-complete pulse |
| sw_clr_i | input | 16 | Per-flag software clear strobes |
| ack_i | input | 1 | Acknowledge strobe from the core |
| ack_vec_i | input | 4 | Vector index being acknowledged |
| flag_o | output | 16 | Flag readback (bit layout as in R2 to R9) |
| irq_o | output | 10 | Request lines, indexed by vector |

## Verification
The hardest cases to reach are level-mode behaviour and collisions between set and clear. In level mode, a software clear must be rejected while the pin is low and accepted only after the high level has passed through the synchronizer. The bench holds the pin low and issues clears, then raises the pin. It waits out the synchronizer delay before clearing again. Collisions are produced by driving a timer set pulse in the same cycle as its software clear, and again in the same cycle as a matching acknowledge. A sweep over every pair of peripheral flags checks the OR of each multi-flag vector. After each set and each clear, the whole request vector is compared with one computed from the flag model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NFLAG       = 16;
  localparam int NVEC        = 10;
  localparam int VEC_W       = 4;
  localparam int SYNC_STAGES = 2;

  // flag positions
  localparam int F_EXT0  = 0;
  localparam int F_EXT1  = 1;
  localparam int F_TMR0  = 2;
  localparam int F_TMR1  = 3;
  localparam int F_TMR2  = 4;
  localparam int F_T2X   = 5;
  localparam int F_U0RX  = 6;
  localparam int F_U0TX  = 7;
  localparam int F_U1RX  = 8;
  localparam int F_U1TX  = 9;
  localparam int F_SPI   = 10;
  localparam int F_I2C   = 14;
  localparam int F_ADC   = 15;

  // vector indices
  localparam int V_EXT0  = 0;
  localparam int V_TMR0  = 1;
  localparam int V_EXT1  = 2;
  localparam int V_TMR1  = 3;
  localparam int V_UART0 = 4;
  localparam int V_TMR2  = 5;
  localparam int V_SPI   = 6;
  localparam int V_I2C   = 7;
  localparam int V_ADC   = 8;
  localparam int V_UART1 = 9;
endpackage

// File: rtl/irq_sync_fall.sv
module irq_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic cur_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur_o  = sync_q[STAGES-1];
  assign fall_o = prev_q & ~cur_o;

  // R2
  single_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/irq_ext_chan.sv
module irq_ext_chan #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_i,
  input  logic ack_hit_i,
  output logic cur_o,
  output logic set_o,
  output logic ack_clr_o
);
  logic fall;

  irq_sync_fall #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .cur_o (cur_o),
    .fall_o(fall)
  );

  // edge: one pulse per falling edge; level: assert while low
  assign set_o     = edge_i ? fall : ~cur_o;
  assign ack_clr_o = ack_hit_i & edge_i;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set wins
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    // R11
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       ext_pin_i,
  input  logic [1:0]       ext_edge_i,
  input  logic             t2x_pin_i,
  input  logic             t0_mode3_i,
  input  logic [2:0]       tmr_ovf_i,
  input  logic [1:0]       uart_rx_done_i,
  input  logic [1:0]       uart_tx_done_i,
  input  logic [3:0]       spi_evt_i,
  input  logic [3:0]       i2c_evt_i,
  input  logic             adc_done_i,
  input  logic [NFLAG-1:0] sw_clr_i,
  input  logic             ack_i,
  input  logic [VEC_W-1:0] ack_vec_i,
  output logic [NFLAG-1:0] flag_o,
  output logic [NVEC-1:0]  irq_o
);
  localparam int NEXT = 2;
  localparam int EXT_FLAG [NEXT] = '{F_EXT0, F_EXT1};
  localparam int EXT_VEC  [NEXT] = '{V_EXT0, V_EXT1};

  logic [NVEC-1:0]  ack_hit;
  logic [NEXT-1:0]  ext_cur, ext_set, ext_ack_clr;
  logic             t2x_cur, t2x_fall;
  logic [NFLAG-1:0] flag_set, hw_clr;

  for (genvar v = 0; v < NVEC; v++) begin : g_ack
    assign ack_hit[v] = ack_i && (ack_vec_i == VEC_W'(v));
  end

  for (genvar n = 0; n < NEXT; n++) begin : g_ext
    irq_ext_chan #(.STAGES(SYNC_STAGES)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (ext_pin_i[n]),
      .edge_i   (ext_edge_i[n]),
      .ack_hit_i(ack_hit[EXT_VEC[n]]),
      .cur_o    (ext_cur[n]),
      .set_o    (ext_set[n]),
      .ack_clr_o(ext_ack_clr[n])
    );
  end

  irq_sync_fall #(.STAGES(SYNC_STAGES)) u_t2x (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (t2x_pin_i),
    .cur_o (t2x_cur),
    .fall_o(t2x_fall)
  );

  always_comb begin
    flag_set             = '0;
    flag_set[F_EXT0]     = ext_set[0];
    flag_set[F_EXT1]     = ext_set[1];
    flag_set[F_TMR0]     = tmr_ovf_i[0];
    flag_set[F_TMR1]     = tmr_ovf_i[1];
    flag_set[F_TMR2]     = tmr_ovf_i[2];
    flag_set[F_T2X]      = t2x_fall;
    flag_set[F_U0RX]     = uart_rx_done_i[0];
    flag_set[F_U0TX]     = uart_tx_done_i[0];
    flag_set[F_U1RX]     = uart_rx_done_i[1];
    flag_set[F_U1TX]     = uart_tx_done_i[1];
    flag_set[F_SPI+:4]   = spi_evt_i;
    flag_set[F_I2C]      = |i2c_evt_i;
    flag_set[F_ADC]      = adc_done_i;

    // only single-cause sources retire on acknowledge
    hw_clr               = '0;
    hw_clr[F_EXT0]       = ext_ack_clr[0];
    hw_clr[F_EXT1]       = ext_ack_clr[1];
    hw_clr[F_TMR0]       = ack_hit[V_TMR0];
    hw_clr[F_TMR1]       = ack_hit[V_TMR1];
  end

  irq_flag_bank #(.N(NFLAG)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flag_set),
    .clr_i (sw_clr_i | hw_clr),
    .q_o   (flag_o)
  );

  always_comb begin
    irq_o          = '0;
    irq_o[V_EXT0]  = flag_o[F_EXT0];
    irq_o[V_TMR0]  = flag_o[F_TMR0] & ~t0_mode3_i;
    irq_o[V_EXT1]  = flag_o[F_EXT1];
    irq_o[V_TMR1]  = flag_o[F_TMR1];
    irq_o[V_UART0] = flag_o[F_U0RX] | flag_o[F_U0TX];
    irq_o[V_TMR2]  = flag_o[F_TMR2] | flag_o[F_T2X];
    irq_o[V_SPI]   = |flag_o[F_SPI+:4];
    irq_o[V_I2C]   = flag_o[F_I2C];
    irq_o[V_ADC]   = flag_o[F_ADC];
    irq_o[V_UART1] = flag_o[F_U1RX] | flag_o[F_U1TX];
  end

  // R3
  edge_ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_vec_i == VEC_W'(V_EXT0) && ext_edge_i[0] && !ext_set[0])
    |=> !flag_o[F_EXT0]);
  // R4
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_edge_i[1] && !ext_cur[1]) |=> flag_o[F_EXT1]);
  // R6
  t2_no_ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_hit[V_TMR2] && flag_o[F_TMR2] && !sw_clr_i[F_TMR2]) |=> flag_o[F_TMR2]);
  // R6
  t2x_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t2x_fall && $past(t2x_cur)) |=> flag_o[F_T2X]);
  // R7
  uart_no_ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_hit[V_UART0] && flag_o[F_U0RX] && !sw_clr_i[F_U0RX]) |=> flag_o[F_U0RX]);
  // R5
  t0_mode3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[V_TMR0] |-> flag_o[F_TMR0]);
endmodule

// File: tb/irq_agg_test.sv
module irq_agg_test;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic [1:0]  ext_pin = 2'b11, ext_edge = 2'b11;
  logic        t2x_pin = 1, t0_mode3 = 0, adc_done = 0, ack = 0;
  logic [2:0]  tmr_ovf = 0;
  logic [1:0]  urx = 0, utx = 0;
  logic [3:0]  spi_evt = 0, i2c_evt = 0, ack_vec = 0;
  logic [15:0] sw_clr = 0, flag_o, exp_f = 0;
  logic [9:0]  irq_o;
  int checks = 0, failures = 0, i2c_k = 0;

  always #5 clk = ~clk;

  irq_agg uut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_pin_i(ext_pin), .ext_edge_i(ext_edge),
    .t2x_pin_i(t2x_pin), .t0_mode3_i(t0_mode3), .tmr_ovf_i(tmr_ovf),
    .uart_rx_done_i(urx), .uart_tx_done_i(utx), .spi_evt_i(spi_evt),
    .i2c_evt_i(i2c_evt), .adc_done_i(adc_done), .sw_clr_i(sw_clr),
    .ack_i(ack), .ack_vec_i(ack_vec), .flag_o(flag_o), .irq_o(irq_o));

  function automatic logic [9:0] irq_of(logic [15:0] f, logic m3);
    logic [9:0] r;
    r[0] = f[0];        r[1] = f[2] & ~m3;  r[2] = f[1];
    r[3] = f[3];        r[4] = f[6] | f[7]; r[5] = f[4] | f[5];
    r[6] = |f[13:10];   r[7] = f[14];       r[8] = f[15];
    r[9] = f[8] | f[9];
    return r;
  endfunction

  function automatic string req_of(int f);
    if (f == 2 || f == 3) return "R5";
    if (f == 4) return "R6";
    if (f >= 6 && f <= 9) return "R7";
    if (f >= 10 && f <= 13) return "R8";
    return "R9";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, 32'(flag_o), 32'(exp_f));
    check(req, 32'(irq_o), 32'(irq_of(exp_f, t0_mode3)));
  endtask

  task automatic drive_src(int f, logic v);
    case (f)
      2: tmr_ovf[0] = v;  3: tmr_ovf[1] = v;  4: tmr_ovf[2] = v;
      6: urx[0] = v;      7: utx[0] = v;      8: urx[1] = v;  9: utx[1] = v;
      10, 11, 12, 13: spi_evt[f-10] = v;
      14: i2c_evt[i2c_k%4] = v;
      15: adc_done = v;
      default: ;
    endcase
  endtask

  task automatic pulse_src(int f);
    drive_src(f, 1); @(negedge clk); drive_src(f, 0);
    if (f == 14) i2c_k++;
    exp_f[f] = 1'b1;
  endtask

  task automatic pulse_clr(int f);
    sw_clr[f] = 1; @(negedge clk); sw_clr[f] = 0;
  endtask

  task automatic pulse_ack(logic [3:0] v);
    ack = 1; ack_vec = v; @(negedge clk); ack = 0;
  endtask

  task automatic wait_pos(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check_all("R1");

    // R2: edge mode ext0, fall seen after 3 rising edges
    ext_pin[0] = 0;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R2", 32'(flag_o[0]), 0);
    wait_pos(0);
    @(posedge clk); @(negedge clk);
    exp_f[0] = 1; check_all("R2");
    // R3: other vector leaves it, own vector clears it
    pulse_ack(4'd2); check_all("R3");
    pulse_ack(4'd0); exp_f[0] = 0; check_all("R3");
    wait_pos(5); check_all("R2");   // held low: no re-set
    ext_pin[0] = 1; wait_pos(4);
    // R3: ext1 in edge mode, vector 2
    ext_pin[1] = 0; wait_pos(3); exp_f[1] = 1; check_all("R2");
    pulse_ack(4'd0); check_all("R3");
    pulse_ack(4'd2); exp_f[1] = 0; check_all("R3");
    ext_pin[1] = 1; wait_pos(4);

    // R4: level mode on ext1
    ext_edge[1] = 0; wait_pos(1); check_all("R4");
    ext_pin[1] = 0; wait_pos(3); exp_f[1] = 1; check_all("R4");
    pulse_ack(4'd2); check_all("R4");
    pulse_clr(1); check_all("R4");
    wait_pos(2); check_all("R4");
    ext_pin[1] = 1; wait_pos(3); check_all("R4");
    pulse_clr(1); exp_f[1] = 0; check_all("R4");
    wait_pos(3); check_all("R4");
    ext_edge[1] = 1;

    // R5: timers, mode 3 gating, acknowledge clears
    t0_mode3 = 1; pulse_src(2); check_all("R5");
    t0_mode3 = 0; #1 check_all("R5");
    pulse_src(3); check_all("R5");
    pulse_ack(4'd1); exp_f[2] = 0; check_all("R5");
    pulse_ack(4'd3); exp_f[3] = 0; check_all("R5");

    // R10: set beats software clear and acknowledge clear
    tmr_ovf[1] = 1; sw_clr[3] = 1; @(negedge clk); tmr_ovf[1] = 0; sw_clr[3] = 0;
    exp_f[3] = 1; check_all("R10");
    tmr_ovf[1] = 1; ack = 1; ack_vec = 4'd3; @(negedge clk); tmr_ovf[1] = 0; ack = 0;
    check_all("R10");
    pulse_clr(3); exp_f[3] = 0; check_all("R11");

    // R6: T2X pin edge, no clear on acknowledge
    t2x_pin = 0; wait_pos(3); exp_f[5] = 1; check_all("R6");
    pulse_src(4); check_all("R6");
    pulse_ack(4'd5); check_all("R6");
    pulse_clr(4); exp_f[4] = 0; check_all("R6");
    pulse_clr(5); exp_f[5] = 0; check_all("R6");
    t2x_pin = 1; wait_pos(3);

    // R7/R8: multi-flag vectors ignore acknowledge
    pulse_src(6); pulse_ack(4'd4); check_all("R7");
    pulse_src(9); pulse_ack(4'd9); check_all("R7");
    pulse_src(11); pulse_ack(4'd6); check_all("R8");
    // R11: out-of-range vectors do nothing
    pulse_src(2);
    for (int v = 10; v < 16; v++) begin
      pulse_ack(4'(v)); check_all("R11");
    end
    for (int f = 0; f < 16; f++) if (exp_f[f]) begin
      pulse_clr(f); exp_f[f] = 0;
    end
    check_all("R11");

    // pairwise sweep over all peripheral flags
    for (int a = 2; a < 16; a++) begin
      if (a == 5) continue;
      for (int b = 2; b < 16; b++) begin
        if (b == 5) continue;
        pulse_src(a); check_all(req_of(a));
        pulse_src(b); check_all(req_of(b));
        pulse_clr(a); exp_f[a] = 0; check_all("R11");
        if (a != b) begin
          pulse_clr(b); exp_f[b] = 0; check_all("R11");
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule